// File: doc/BRIEF.md
# Transfer Descriptor Slot Scheduler

This block chooses which of 32 transfer-descriptor slots a host controller's processing engine works on next. Software fills slots in a buffer and describes them with two 32-bit masks held here: a skip mask, where a set bit tells the scheduler to pass over that slot, and an end mask, where a set bit marks the final occupied slot of a pass. Bit n of either mask belongs to slot n. The scheduler walks the slots in ascending order, leaves out skipped ones, and after the end slot has been processed it starts again at slot 0.

The engine signals completion of the current slot with a one-cycle `done` pulse, and the next slot index appears on the following clock edge. The search is a single-cycle priority pick over the eligible slots at or above the start position, with a fallback to the lowest eligible slot. Software reaches the masks and a read-only copy of the active slot index through a small command port. Bit 7 of the command byte selects a write, and bits 6:0 select the register. Software can use the active index to see which slots are safe to refill.

Top module: `td_slot_sched`

## Requirements
- R1: After reset, both masks read zero, `slot_idx` is 0 and `slot_valid` is low.
- R2: A command with bit 7 set and low bits 1Ch writes the skip mask. A command with bit 7 set and low bits 1Dh writes the end mask. The write takes effect at the clock edge where `reg_cs` is high. A command with bit 7 clear returns the selected mask on `reg_rdata` in the same cycle.
- R3: Read command 1Eh returns the active slot index in bits 4:0, with bits 31:5 at zero. Write command 9Eh changes neither mask nor the index.
- R4: While `en` is low and no slot is active, `slot_valid` stays low. When `en` is high and no slot is active, the next edge selects the lowest eligible slot at or after the stored start position. The start position is 0 after reset.
- R5: On a `done` pulse while `en` is high, the next edge selects the lowest slot above the current one whose skip bit is 0. Slots with skip bit 1 are never selected.
- R6: When `done` arrives for the slot that ends the pass, the search restarts from slot 0.
- R7: When no end bit is set, slot 31 ends the pass.
- R8: When several end bits are set, the lowest-numbered one ends the pass, and slots above it are never selected.
- R9: When every slot from 0 up to the pass end is skipped, `slot_valid` goes low and the index holds. Selection resumes once a mask write makes a slot eligible.
- R10: A mask write leaves the active index and `slot_valid` unchanged. The new mask is used at the next selection.
- R11: A `done` pulse while `en` is low drops `slot_valid` and keeps the index. When `en` returns high, the search continues from the slot after the finished one.
- R12: While a slot is active and no `done` arrives, `slot_idx` and `slot_valid` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Allows slot selection |
| done | input | 1 | One-cycle pulse when the active slot finishes |
| reg_cs | input | 1 | Register access strobe |
| reg_cmd | input | 8 | Command byte: bit 7 selects write, bits 6:0 select the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| slot_valid | output | 1 | A slot is active |
| slot_idx | output | 5 | Active slot index |

## Verification
The in-module assertions check four behaviours on every cycle. The index and valid flag hold between `done` pulses. A slot chosen after `done` never had its skip bit set. No slot is started while `en` is low. A fully skipped mask keeps the block idle. Only the bench scenarios can show the exact slot order: wrap at the end slot, the implicit slot 31 end, the choice of the lowest of several end bits, resumption after a pause, and register readback and write isolation.

// File: rtl/td_slot_sched.sv
module td_slot_sched #(
  parameter int N = 32,
  parameter logic [6:0] SKIP_CODE = 7'h1C,
  parameter logic [6:0] END_CODE  = 7'h1D,
  parameter logic [6:0] ACT_CODE  = 7'h1E
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         done,
  input  logic         reg_cs,
  input  logic [7:0]   reg_cmd,
  input  logic [N-1:0] reg_wdata,
  output logic [N-1:0] reg_rdata,
  output logic         slot_valid,
  output logic [$clog2(N)-1:0] slot_idx
);
  localparam int IW = $clog2(N);
  localparam logic [N-1:0] ONES = '1;

  logic [N-1:0]  skip_q, end_q;
  logic [IW-1:0] start_q;

  function automatic logic [IW-1:0] lowest(input logic [N-1:0] v);
    lowest = '0;
    for (int i = N - 1; i >= 0; i--)
      if (v[i]) lowest = IW'(i);
  endfunction

  wire [IW-1:0] pass_end = |end_q ? lowest(end_q) : IW'(N - 1);
  wire [N-1:0]  in_pass  = ONES >> (IW'(N - 1) - pass_end);
  wire [N-1:0]  elig     = ~skip_q & in_pass;
  wire          fire     = slot_valid & done;
  wire [IW-1:0] after    = (slot_idx >= pass_end) ? '0 : slot_idx + 1'b1;
  wire [IW-1:0] from     = fire ? after : start_q;
  wire [N-1:0]  upper    = elig & (ONES << from);
  wire [IW-1:0] pick     = |upper ? lowest(upper) : lowest(elig);
  wire          try_sel  = en & (fire | ~slot_valid);
  wire          wr       = reg_cs & reg_cmd[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skip_q <= '0;
      end_q  <= '0;
    end else if (wr) begin
      if (reg_cmd[6:0] == SKIP_CODE) skip_q <= reg_wdata;
      if (reg_cmd[6:0] == END_CODE)  end_q  <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_valid <= 1'b0;
      slot_idx   <= '0;
      start_q    <= '0;
    end else begin
      if (fire) start_q <= after;
      if (try_sel) begin
        slot_valid <= |elig;
        if (|elig) slot_idx <= pick;
      end else if (fire) begin
        slot_valid <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_cs && !reg_cmd[7]) begin
      case (reg_cmd[6:0])
        SKIP_CODE: reg_rdata = skip_q;
        END_CODE:  reg_rdata = end_q;
        ACT_CODE:  reg_rdata = {{(N-IW){1'b0}}, slot_idx};
        default:   reg_rdata = '0;
      endcase
    end
  end

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && !done) |=> (slot_valid && $stable(slot_idx)));

  // R5
  pick_unskipped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && done && en) |=>
      (!slot_valid || ((($past(skip_q) >> slot_idx) & N'(1)) == N'(0))));

  // R4
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !slot_valid) |=> !slot_valid);

  // R11
  pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && done && !en) |=> (!slot_valid && $stable(slot_idx)));

  // R9
  all_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((&skip_q) && !slot_valid && !wr) |=> !slot_valid);
endmodule

// File: tb/td_slot_sched_test.sv
`timescale 1ns/1ps
module td_slot_sched_test;
  logic clk = 0, rst_n = 0, en = 0, done = 0, reg_cs = 0;
  logic [7:0] reg_cmd = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic slot_valid;
  logic [4:0] slot_idx;
  int compared = 0, mismatched = 0;
  int exp_q[$];
  string tag_q[$];

  td_slot_sched uut (.clk(clk), .rst_n(rst_n), .en(en), .done(done),
    .reg_cs(reg_cs), .reg_cmd(reg_cmd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .slot_valid(slot_valid), .slot_idx(slot_idx));

  always #10 clk = ~clk;

  task automatic chk(input int act, input int exp, input string tag);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected {valid,idx} per edge after outputs settle
  always @(posedge clk) begin
    if (exp_q.size() > 0) begin
      int e;
      string t;
      #5;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk({31'd0, slot_valid} * 32 + {27'd0, slot_idx}, e, t);
    end
  end

  // driver: one cycle, optional done pulse, expected result pushed
  task automatic step(input bit d, input bit v, input int idx, input string tag);
    @(negedge clk);
    done = d;
    exp_q.push_back(v * 32 + idx);
    tag_q.push_back(tag);
    @(negedge clk);
    done = 0;
  endtask

  task automatic wr(input logic [7:0] cmd, input logic [31:0] d);
    @(negedge clk);
    reg_cs = 1; reg_cmd = cmd; reg_wdata = d;
    @(negedge clk);
    reg_cs = 0;
  endtask

  task automatic rd(input logic [7:0] cmd, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_cs = 1; reg_cmd = cmd;
    #1 chk(reg_rdata, exp, tag);
    reg_cs = 0;
  endtask

  initial begin
    #4000000;
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    @(negedge clk);
    chk(slot_valid, 0, "R1 valid");
    chk(slot_idx, 0, "R1 idx");
    rd(8'h1C, 0, "R1 skip");
    rd(8'h1D, 0, "R1 end");
    // R4 disabled stays idle
    step(0, 0, 0, "R4 disabled");
    step(0, 0, 0, "R4 disabled");
    // R2 writes and readback
    wr(8'h9C, 32'h0000_000D);
    wr(8'h9D, 32'h0000_0040);
    rd(8'h1C, 32'h0000_000D, "R2 skip");
    rd(8'h1D, 32'h0000_0040, "R2 end");
    // R4 enable picks slot 1
    @(negedge clk); en = 1;
    exp_q.push_back(32 + 1); tag_q.push_back("R4 start");
    step(0, 1, 1, "R12 hold");
    step(0, 1, 1, "R12 hold");
    step(1, 1, 4, "R5 skip 2,3");
    step(1, 1, 5, "R5 ascend");
    rd(8'h1E, 5, "R3 active");
    step(1, 1, 6, "R5 to end");
    step(1, 1, 1, "R6 wrap");
    // R8 several end bits, R10 write isolation
    wr(8'h9D, 32'h0000_0050);
    chk({31'd0, slot_valid} * 32 + {27'd0, slot_idx}, 32 + 1, "R10 after write");
    step(1, 1, 4, "R8 next");
    step(1, 1, 1, "R8 lowest end");
    // R7 implicit end at 31
    wr(8'h9D, 32'h0);
    wr(8'h9C, 32'h7FFF_FFFE);
    chk({31'd0, slot_valid} * 32 + {27'd0, slot_idx}, 32 + 1, "R10 after write");
    step(1, 1, 31, "R7 reach 31");
    step(1, 1, 0, "R7 wrap");
    // R11 pause on done with en low
    @(negedge clk); en = 0;
    step(1, 0, 0, "R11 drop");
    step(0, 0, 0, "R11 idle");
    @(negedge clk); en = 1;
    exp_q.push_back(32 + 31); tag_q.push_back("R11 resume");
    // R9 fully skipped
    wr(8'h9C, 32'hFFFF_FFFF);
    step(1, 0, 31, "R9 idle");
    step(0, 0, 31, "R9 stays");
    @(negedge clk);
    reg_cs = 1; reg_cmd = 8'h9C; reg_wdata = 32'hFFFF_FFF7;
    exp_q.push_back(31); tag_q.push_back("R9 write edge");
    @(negedge clk); reg_cs = 0;
    exp_q.push_back(32 + 3); tag_q.push_back("R9 resume");
    @(negedge clk);
    // R3 readback and write ignored
    rd(8'h1E, 3, "R3 active");
    wr(8'h9E, 32'hFFFF_FFFF);
    rd(8'h1E, 3, "R3 write ignored");
    rd(8'h1C, 32'hFFFF_FFF7, "R3 skip untouched");
    rd(8'h1D, 0, "R3 end untouched");
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule